// File: doc/BRIEF.md
# Shared Scan Chain Refresh Controller

This block sequences a long serial scan chain that threads through many small user designs. Each design owns one slot of the chain. A slot is a stage of `2*IO_W` flops: half carries input bits toward the design and half carries the design's output bits back. Only one slot is active at a time, chosen by a select value. The controller repeats a refresh without pause. Each refresh captures every design's outputs into the chain and shifts the whole chain by one full length. While it shifts, it writes the input word into the active slot and zeros into every other slot, and it picks the active slot's output bits off the chain end. It then pulses a latch so that all designs take their new inputs.

The select value and the input word are sampled once, at the start of each refresh. The captured output word appears on `out_bits` together with a one-cycle `refresh_done` strobe and holds until the next strobe. The result bus has no back-pressure: a consumer that wants every result must take it in the strobe cycle. The scan clock runs at half the system clock, so one refresh lasts `32*NUM_SLOTS + 4` cycles with the default `IO_W` of 8.

Top module: `scan_chain_ctrl`

## Requirements
- R1: While `rst` is high (synchronous), `scan_clk`, `scan_sel`, `latch_en`, `refresh_done` and `out_bits` are all 0. In the first cycle after `rst` falls, `scan_sel` is already high, so the first refresh starts without any request.
- R2: `scan_clk` is never high for two cycles in a row, and `scan_dout` does not change in a cycle where `scan_clk` is high. Each chain bit therefore takes one low cycle followed by one high cycle.
- R3: Each refresh opens with `scan_sel` high for exactly 2 cycles, with one rising `scan_clk` edge inside them. `scan_sel` is never high together with `latch_en`.
- R4: Between the capture and the latch there are exactly `2*IO_W*NUM_SLOTS` rising `scan_clk` edges with `scan_sel` low.
- R5: Chain layout: positions are counted from the flop fed by `scan_dout`. Slot s occupies positions `2*IO_W*s + j` for j in 0..2*IO_W-1. Position `2*IO_W*s + i` (i < IO_W) is input bit i, and position `2*IO_W*s + IO_W + i` is output bit i. A rising `scan_clk` with `scan_sel` high loads the output positions from the designs. Otherwise each rising edge moves every bit one position away from the entry. At `latch_en` the active slot's input positions hold the sampled `in_bits`, and every other slot's input positions hold 0.
- R6: The `out_bits` presented with a strobe equal the output bits that the active slot drove at that refresh's capture edge, with bit i taken from chain position `2*IO_W*sel + IO_W + i`.
- R7: `latch_en` is high for one cycle, directly after the high phase of the last shift. `refresh_done` is high in the following cycle and only then, for one cycle. Consecutive strobes are `4*IO_W*NUM_SLOTS + 4` cycles apart.
- R8: `out_bits` changes only in a cycle where `refresh_done` is high.
- R9: `active_sel` and `in_bits` are sampled only when a refresh starts. Changing them in mid-refresh has no effect on that refresh's written inputs or captured outputs.
- R10: A select value of `NUM_SLOTS` or more matches no slot: every slot receives zeros and `out_bits` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| active_sel | input | SEL_W | Index of the active slot, sampled at refresh start |
| in_bits | input | IO_W | Input word for the active slot, sampled at refresh start |
| scan_din | input | 1 | Serial data returning from the chain end |
| scan_clk | output | 1 | Chain shift clock, half the system rate |
| scan_dout | output | 1 | Serial data into the chain entry |
| scan_sel | output | 1 | Capture select: the designs' outputs load on the next scan clock edge |
| latch_en | output | 1 | Transfers the chain's input positions into the designs |
| out_bits | output | IO_W | Captured output word of the active slot |
| refresh_done | output | 1 | One-cycle strobe marking a new `out_bits` |

## Verification
The hardest case to reach from the ports is a select or input word that changes while a refresh is under way, after the snapshot has been taken. The stimulus sets up each refresh in the strobe cycle of the previous one. On alternate refreshes it then rewrites `active_sel` and `in_bits` about forty cycles later, deep inside the shift phase. A behavioural chain model in the bench checks that the latched words and the returned outputs still follow the values from the refresh start. The out-of-range select is also driven with the first invalid index and with the largest 9-bit value.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CAP_LO = 3'd1,
    ST_CAP_HI = 3'd2,
    ST_SH_LO  = 3'd3,
    ST_SH_HI  = 3'd4,
    ST_LATCH  = 3'd5,
    ST_DONE   = 3'd6
  } seq_state_t;

endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic last,
  output logic load,
  output logic dec,
  output logic sample,
  output logic commit,
  output logic scan_clk,
  output logic scan_sel,
  output logic latch_en,
  output logic refresh_done
);

  seq_state_t state;
  seq_state_t nxt;

  always_comb begin
    case (state)
      ST_IDLE:   nxt = ST_CAP_LO;
      ST_CAP_LO: nxt = ST_CAP_HI;
      ST_CAP_HI: nxt = ST_SH_LO;
      ST_SH_LO:  nxt = ST_SH_HI;
      ST_SH_HI:  nxt = last ? ST_LATCH : ST_SH_LO;
      ST_LATCH:  nxt = ST_DONE;
      ST_DONE:   nxt = ST_CAP_LO;
      default:   nxt = ST_IDLE;
    endcase
  end

  // Pin values are registered from the next state, so the pins carry no decode glitches.
  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      scan_clk     <= 1'b0;
      scan_sel     <= 1'b0;
      latch_en     <= 1'b0;
      refresh_done <= 1'b0;
    end else begin
      state        <= nxt;
      scan_clk     <= (nxt == ST_CAP_HI) || (nxt == ST_SH_HI);
      scan_sel     <= (nxt == ST_CAP_LO) || (nxt == ST_CAP_HI);
      latch_en     <= (nxt == ST_LATCH);
      refresh_done <= (nxt == ST_DONE);
    end
  end

  assign load   = !rst && (nxt == ST_CAP_LO);
  assign dec    = (state == ST_SH_HI) && !last;
  assign sample = (state == ST_SH_LO);
  assign commit = (state == ST_LATCH);

endmodule

// File: rtl/scan_pos_ctr.sv
module scan_pos_ctr #(
  parameter int NUM_SLOTS = 500,
  parameter int SLOT_W    = 9,
  parameter int BIT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              dec,
  output logic [SLOT_W-1:0] slot,
  output logic [BIT_W-1:0]  bidx,
  output logic              last
);

  // Counts down the remaining distance from the chain entry: slot, then bit in slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      bidx <= '0;
    end else if (load) begin
      slot <= SLOT_W'(NUM_SLOTS - 1);
      bidx <= '1;
    end else if (dec) begin
      if (bidx == '0) begin
        bidx <= '1;
        slot <= slot - 1'b1;
      end else begin
        bidx <= bidx - 1'b1;
      end
    end
  end

  assign last = (slot == '0) && (bidx == '0);

endmodule

// File: rtl/scan_io.sv
module scan_io #(
  parameter int IO_W   = 8,
  parameter int SEL_W  = 9,
  parameter int SLOT_W = 9,
  parameter int BIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              sample,
  input  logic              commit,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [IO_W-1:0]   din_in,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BIT_W-1:0]  bidx,
  input  logic              scan_din,
  output logic              scan_dout,
  output logic [IO_W-1:0]   out_bits
);

  localparam int IDX_W = BIT_W - 1;
  localparam int CMP_W = SEL_W + SLOT_W;

  logic [SEL_W-1:0] sel_q;
  logic [IO_W-1:0]  din_q;
  logic [IO_W-1:0]  cap_q;
  logic             hit;
  logic             wr_half;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      din_q <= '0;
    end else if (load) begin
      sel_q <= sel_in;
      din_q <= din_in;
    end
  end

  assign hit       = (CMP_W'(slot) == CMP_W'(sel_q));
  assign wr_half   = !bidx[BIT_W-1];
  assign idx       = bidx[IDX_W-1:0];
  assign scan_dout = hit && wr_half && din_q[idx];

  for (genvar i = 0; i < IO_W; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst || load) begin
        cap_q[i] <= 1'b0;
      end else if (sample && hit && !wr_half && (idx == IDX_W'(i))) begin
        cap_q[i] <= scan_din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bits <= '0;
    end else if (commit) begin
      out_bits <= cap_q;
    end
  end

endmodule

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl #(
  parameter int NUM_SLOTS = 500,
  parameter int IO_W      = 8,
  parameter int SEL_W     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] active_sel,
  input  logic [IO_W-1:0]  in_bits,
  input  logic             scan_din,
  output logic             scan_clk,
  output logic             scan_dout,
  output logic             scan_sel,
  output logic             latch_en,
  output logic [IO_W-1:0]  out_bits,
  output logic             refresh_done
);

  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int BIT_W  = $clog2(2 * IO_W);

  logic              load;
  logic              dec;
  logic              sample;
  logic              commit;
  logic              last;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bidx;

  scan_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .last         (last),
    .load         (load),
    .dec          (dec),
    .sample       (sample),
    .commit       (commit),
    .scan_clk     (scan_clk),
    .scan_sel     (scan_sel),
    .latch_en     (latch_en),
    .refresh_done (refresh_done)
  );

  scan_pos_ctr #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .BIT_W     (BIT_W)
  ) u_pos (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .dec  (dec),
    .slot (slot),
    .bidx (bidx),
    .last (last)
  );

  scan_io #(
    .IO_W   (IO_W),
    .SEL_W  (SEL_W),
    .SLOT_W (SLOT_W),
    .BIT_W  (BIT_W)
  ) u_io (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .sample    (sample),
    .commit    (commit),
    .sel_in    (active_sel),
    .din_in    (in_bits),
    .slot      (slot),
    .bidx      (bidx),
    .scan_din  (scan_din),
    .scan_dout (scan_dout),
    .out_bits  (out_bits)
  );

endmodule

// File: rtl/scan_chain_ctrl_chk.sv
module scan_chain_ctrl_chk #(
  parameter int IO_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            scan_clk,
  input logic            scan_dout,
  input logic            scan_sel,
  input logic            latch_en,
  input logic [IO_W-1:0] out_bits,
  input logic            refresh_done
);

  a_r2_clk_high_once: assert property (@(posedge clk) disable iff (rst)
    scan_clk |=> !scan_clk);

  a_r2_data_steady: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_clk) |-> $stable(scan_dout));

  a_r3_sel_no_latch: assert property (@(posedge clk) disable iff (rst)
    !(scan_sel && latch_en));

  a_r3_sel_two_cycles: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_sel) |=> scan_sel);

  a_r3_sel_ends: assert property (@(posedge clk) disable iff (rst)
    (scan_sel && $past(scan_sel)) |=> !scan_sel);

  a_r7_latch_then_done: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> (refresh_done && !latch_en));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    refresh_done |=> !refresh_done);

  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    !refresh_done |-> $stable(out_bits));

endmodule

bind scan_chain_ctrl scan_chain_ctrl_chk #(.IO_W(IO_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .scan_clk     (scan_clk),
  .scan_dout    (scan_dout),
  .scan_sel     (scan_sel),
  .latch_en     (latch_en),
  .out_bits     (out_bits),
  .refresh_done (refresh_done)
);

// File: tb/test_scan_chain_ctrl.sv
module test_scan_chain_ctrl;

  localparam int N      = 4;
  localparam int W      = 8;
  localparam int SW     = 9;
  localparam int L      = 2 * W * N;
  localparam int PERIOD = 2 * L + 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] active_sel = '0;
  logic [W-1:0]  in_bits = '0;
  logic          scan_din;
  logic          scan_clk, scan_dout, scan_sel, latch_en, refresh_done;
  logic [W-1:0]  out_bits;

  always #10 clk = ~clk;

  scan_chain_ctrl #(.NUM_SLOTS(N), .IO_W(W), .SEL_W(SW)) i_scan_chain_ctrl (
    .clk(clk), .rst(rst), .active_sel(active_sel), .in_bits(in_bits),
    .scan_din(scan_din), .scan_clk(scan_clk), .scan_dout(scan_dout),
    .scan_sel(scan_sel), .latch_en(latch_en), .out_bits(out_bits),
    .refresh_done(refresh_done)
  );

  // Behavioural chain with the layout of R5
  logic [L-1:0] chain = '0;
  logic [W-1:0] slot_out [N];
  logic [W-1:0] latched  [N];

  assign scan_din = chain[L-1];

  always @(posedge scan_clk) begin
    if (scan_sel) begin
      for (int s = 0; s < N; s++)
        for (int i = 0; i < W; i++)
          chain[2*W*s + W + i] <= slot_out[s][i];
    end else begin
      chain <= {chain[L-2:0], scan_dout};
    end
  end

  always @(posedge latch_en) begin
    for (int s = 0; s < N; s++)
      for (int i = 0; i < W; i++)
        latched[s][i] = chain[2*W*s + i];
  end

  typedef struct {
    logic [SW-1:0] sel;
    logic [W-1:0]  din;
    logic [W-1:0]  exp;
    string         tag;
  } item_t;

  item_t q[$];
  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  logic [SW-1:0] sels [8] = '{9'd0, 9'd3, 9'd1, 9'd2, 9'd4, 9'd511, 9'd3, 9'd0};

  task automatic set_vec(input int v, input bit mid_change);
    item_t it;
    active_sel = sels[v];
    in_bits    = 8'(8'hA9 + v * 8'h5D);
    for (int s = 0; s < N; s++)
      slot_out[s] = 8'((8'h3C * (v + 1)) ^ (s * 8'h47 + 8'h12));
    it.sel = active_sel;
    it.din = in_bits;
    it.exp = (active_sel < N) ? slot_out[active_sel] : '0;
    it.tag = (active_sel >= N) ? "R10" : (mid_change ? "R9" : "R6");
    q.push_back(it);
  endtask

  task automatic wait_done;
    @(negedge clk);
    while (!refresh_done) @(negedge clk);
  endtask

  // Monitor: per-refresh counters and scoreboard comparison
  logic       prev_clk = 1'b0, prev_dout = 1'b0;
  logic [W-1:0] prev_out = '0;
  int rises = 0, selc = 0, latc = 0, hi_run = 0, max_hi = 0;
  int dout_bad = 0, out_bad = 0, cyc = 0;
  bit first = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (scan_clk && !prev_clk && !scan_sel) rises++;
      if (scan_sel) selc++;
      if (latch_en) latc++;
      hi_run = scan_clk ? hi_run + 1 : 0;
      if (hi_run > max_hi) max_hi = hi_run;
      if (scan_clk && (scan_dout != prev_dout)) dout_bad++;
      if (!refresh_done && (out_bits != prev_out)) out_bad++;
      if (refresh_done && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(out_bits == it.exp, it.tag, "captured out_bits", 32'(out_bits), 32'(it.exp));
        for (int s = 0; s < N; s++) begin
          logic [W-1:0] e;
          e = (SW'(s) == it.sel) ? it.din : '0;
          chk(latched[s] == e, (it.sel >= N) ? "R10" : ((it.tag == "R9") ? "R9" : "R5"),
              $sformatf("latched slot %0d", s), 32'(latched[s]), 32'(e));
        end
        chk(rises == L, "R4", "shift edges", 32'(rises), 32'(L));
        chk(selc == 2, "R3", "scan_sel cycles", 32'(selc), 32'd2);
        chk(latc == 1, "R7", "latch_en cycles", 32'(latc), 32'd1);
        chk(max_hi == 1, "R2", "scan_clk high run", 32'(max_hi), 32'd1);
        chk(dout_bad == 0, "R2", "scan_dout moved while clock high", 32'(dout_bad), 32'd0);
        chk(out_bad == 0, "R8", "out_bits changed off strobe", 32'(out_bad), 32'd0);
        if (!first) chk(cyc == PERIOD, "R7", "strobe spacing", 32'(cyc), 32'(PERIOD));
        first = 1'b0;
        rises = 0; selc = 0; latc = 0; max_hi = 0; dout_bad = 0; out_bad = 0; cyc = 0;
      end
      prev_clk  = scan_clk;
      prev_dout = scan_dout;
      prev_out  = out_bits;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
    finish_up();
  end

  initial begin
    set_vec(0, 1'b0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_bits == '0, "R1", "out_bits in reset", 32'(out_bits), 32'd0);
    chk({scan_clk, scan_sel, latch_en, refresh_done} == 4'b0, "R1", "control pins in reset",
        32'({scan_clk, scan_sel, latch_en, refresh_done}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(scan_sel == 1'b1, "R1", "capture starts after release", 32'(scan_sel), 32'd1);
    for (int v = 1; v < 8; v++) begin
      wait_done();
      set_vec(v, v % 2 == 1);
      if (v % 2 == 1) begin
        // R9: disturb the select and input word in mid-refresh
        repeat (40) @(negedge clk);
        active_sel = active_sel ^ 9'h1;
        in_bits    = ~in_bits;
      end
    end
    wait_done();
    @(negedge clk);
    chk(q.size() == 0, "R7", "refreshes left unchecked", 32'(q.size()), 32'd0);
    finish_up();
  end

endmodule